// File: doc/BRIEF.md
# Directory Home Controller

This block sits at the home node of a distributed shared-memory machine. For each memory block it owns, it records one of three directory states: uncached, shared (one or more nodes hold a clean copy and home memory is current), or exclusive (one node holds the block and home memory may be stale). It also records a presence vector with one bit per node, and in the exclusive state the single set bit names the owner. Requesting nodes send it read misses, write misses and write-backs. It answers with data replies, invalidates to sharers, and fetch or fetch-and-invalidate messages to an owner. It keeps a small backing memory current with data that owners return.

Messages arrive one at a time on a valid/ready request channel and leave on a valid/ready message channel. Owner data comes back on a separate valid/ready channel. The controller serves one request at a time. While it sends invalidates or waits for owner data, it holds the request channel not-ready, so later requests to the same block wait and are served in arrival order.

Top module: `dir_home`

## Requirements
- R1: After reset every block is uncached with an empty presence vector and zero data, `req_ready` is 1, and `msg_valid` and `own_ready` are 0.
- R2: A read miss (`req_kind` 0) to an uncached block produces a data reply (`msg_kind` 0) to the requester carrying the memory value. The block becomes shared with the requester as its only sharer.
- R3: A write miss (`req_kind` 1) to an uncached block produces a data reply to the requester. The block becomes exclusive, owned by the requester.
- R4: A read miss to a shared block produces a data reply from memory and adds the requester to the presence vector without removing anyone.
- R5: A write miss to a shared block sends one invalidate (`msg_kind` 1) to each sharer other than the requester, in strictly ascending node order. The data reply goes out only after the last invalidate. The block then becomes exclusive, owned by the requester.
- R6: A read miss to an exclusive block sends a fetch (`msg_kind` 2) to the owner and waits on the owner-data channel. The returned data is written to memory and appears in the data reply in the cycle after it is accepted. The block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-and-invalidate (`msg_kind` 3) to the owner. The returned data is forwarded to the requester, who becomes the new owner.
- R8: A write-back (`req_kind` 2) from the owner of an exclusive block writes its data to memory. The block becomes uncached with an empty presence vector, and no message is sent.
- R9: A write-back from a node that is not the owner, or to a block that is not exclusive, produces no message and changes neither memory nor directory state.
- R10: While a request is being served (invalidates, fetch, owner wait or reply pending), `req_ready` is 0. Owner data is accepted only while `own_ready` is 1.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, the outgoing message and all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NID_W | Requesting node |
| req_addr | input | AW | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken this cycle |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_node | output | NID_W | Destination node |
| msg_addr | output | AW | Block index |
| msg_data | output | DATA_W | Reply data (zero for other kinds) |
| own_valid | input | 1 | Owner data present |
| own_ready | output | 1 | Controller waits for owner data |
| own_data | input | DATA_W | Data returned by the owner |

## Verification
Two events can fall in the same cycle. The first is a new request arriving while the controller waits for owner data on the same block. The second is back-pressure on the message channel while invalidates are being issued. The bench holds a read miss to a block valid during its fetch wait and checks that `req_ready` stays low. It then checks that the first reply carries the owner's data and that the held request is served next from the updated memory. Separately, it holds `msg_ready` low for several cycles in the middle of an invalidate sequence and checks that each held message stays unchanged and that the destinations still rise in node order.

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int NID_W = $clog2(NODES),
  localparam int AW    = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [NID_W-1:0]  req_node,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_kind,
  output logic [NID_W-1:0]  msg_node,
  output logic [AW-1:0]     msg_addr,
  output logic [DATA_W-1:0] msg_data,
  input  logic              own_valid,
  output logic              own_ready,
  input  logic [DATA_W-1:0] own_data
);

  typedef enum logic [2:0] {P_IDLE, P_INV, P_FETCH, P_WAIT, P_REPLY} phase_t;
  typedef enum logic [1:0] {D_UNC, D_SHR, D_EXC} dstate_t;

  localparam logic [1:0] K_RD = 2'd0;
  localparam logic [1:0] K_WR = 2'd1;
  localparam logic [1:0] K_WB = 2'd2;

  phase_t              ph_q;
  dstate_t             dst   [BLOCKS];
  logic [NODES-1:0]    dsh   [BLOCKS];
  logic [DATA_W-1:0]   mem   [BLOCKS];

  logic [1:0]          kind_q;
  logic [NID_W-1:0]    node_q;
  logic [AW-1:0]       addr_q;
  logic [NID_W-1:0]    own_q;
  logic [NODES-1:0]    pend_q;
  dstate_t             nst_q;
  logic [NODES-1:0]    nsh_q;

  dstate_t             cur_st;
  logic [NODES-1:0]    cur_sh;
  logic [NODES-1:0]    req_bit;
  logic [NODES-1:0]    others;
  logic [NID_W-1:0]    cur_own;
  logic [NID_W-1:0]    inv_idx;
  logic [NODES-1:0]    pend_left;

  assign cur_st    = dst[req_addr];
  assign cur_sh    = dsh[req_addr];
  assign req_bit   = NODES'(1) << req_node;
  assign others    = cur_sh & ~req_bit;
  assign pend_left = pend_q & ~(NODES'(1) << inv_idx);

  always_comb begin
    cur_own = '0;
    for (int i = 0; i < NODES; i++)
      if (cur_sh[i]) cur_own = NID_W'(i);
  end

  always_comb begin
    inv_idx = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (pend_q[i]) inv_idx = NID_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= P_IDLE;
      kind_q <= '0;
      node_q <= '0;
      addr_q <= '0;
      own_q  <= '0;
      pend_q <= '0;
      nst_q  <= D_UNC;
      nsh_q  <= '0;
      for (int b = 0; b < BLOCKS; b++) begin
        dst[b] <= D_UNC;
        dsh[b] <= '0;
        mem[b] <= '0;
      end
    end else begin
      case (ph_q)
        P_IDLE: if (req_valid) begin
          kind_q <= req_kind;
          node_q <= req_node;
          addr_q <= req_addr;
          case (req_kind)
            K_RD: begin
              nst_q <= D_SHR;
              if (cur_st == D_UNC) begin
                nsh_q <= req_bit;
                ph_q  <= P_REPLY;
              end else if (cur_st == D_SHR) begin
                nsh_q <= cur_sh | req_bit;
                ph_q  <= P_REPLY;
              end else begin
                nsh_q <= cur_sh | req_bit;
                own_q <= cur_own;
                ph_q  <= P_FETCH;
              end
            end
            K_WR: begin
              nst_q <= D_EXC;
              nsh_q <= req_bit;
              if (cur_st == D_UNC) begin
                ph_q <= P_REPLY;
              end else if (cur_st == D_SHR) begin
                pend_q <= others;
                ph_q   <= (others != '0) ? P_INV : P_REPLY;
              end else begin
                own_q <= cur_own;
                ph_q  <= P_FETCH;
              end
            end
            K_WB: begin
              if (cur_st == D_EXC && cur_sh == req_bit) begin
                mem[req_addr] <= req_data;
                dst[req_addr] <= D_UNC;
                dsh[req_addr] <= '0;
              end
            end
            default: ;
          endcase
        end
        P_INV: if (msg_ready) begin
          pend_q <= pend_left;
          if (pend_left == '0) ph_q <= P_REPLY;
        end
        P_FETCH: if (msg_ready) ph_q <= P_WAIT;
        P_WAIT: if (own_valid) begin
          mem[addr_q] <= own_data;
          ph_q        <= P_REPLY;
        end
        P_REPLY: if (msg_ready) begin
          dst[addr_q] <= nst_q;
          dsh[addr_q] <= nsh_q;
          ph_q        <= P_IDLE;
        end
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assign req_ready = (ph_q == P_IDLE);
  assign own_ready = (ph_q == P_WAIT);
  assign msg_valid = (ph_q == P_INV) || (ph_q == P_FETCH) || (ph_q == P_REPLY);
  assign msg_kind  = (ph_q == P_INV)   ? 2'd1 :
                     (ph_q == P_FETCH) ? ((kind_q == K_WR) ? 2'd3 : 2'd2) : 2'd0;
  assign msg_node  = (ph_q == P_INV)   ? inv_idx :
                     (ph_q == P_FETCH) ? own_q : node_q;
  assign msg_addr  = addr_q;
  assign msg_data  = (ph_q == P_REPLY) ? mem[addr_q] : '0;

endmodule

module dir_home_chk #(
  parameter int NID_W  = 2,
  parameter int AW     = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [1:0]        msg_kind,
  input logic [NID_W-1:0]  msg_node,
  input logic [AW-1:0]     msg_addr,
  input logic [DATA_W-1:0] msg_data,
  input logic              own_valid,
  input logic              own_ready,
  input logic [DATA_W-1:0] own_data
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> req_ready && !msg_valid && !own_ready);

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_node)
                                && $stable(msg_addr) && $stable(msg_data));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid || own_ready) |-> !req_ready);

  // R5
  inv_order_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready && msg_kind == 2'd1 |=>
      !(msg_valid && msg_kind == 2'd1) || (msg_node > $past(msg_node)));

  // R6
  own_forward_chk: assert property (@(posedge clk) disable iff (rst)
    own_valid && own_ready |=> msg_valid && msg_kind == 2'd0 && msg_data == $past(own_data));

  // R9
  wb_silent_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_kind == 2'd2 |=> !msg_valid);

endmodule

bind dir_home dir_home_chk #(.NID_W(NID_W), .AW(AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_node(msg_node),
  .msg_addr(msg_addr), .msg_data(msg_data), .own_valid(own_valid), .own_ready(own_ready),
  .own_data(own_data)
);

// File: tb/sim_dir_home.sv
module sim_dir_home;
  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_kind = 0;
  logic [1:0] req_node = 0;
  logic [2:0] req_addr = 0;
  logic [15:0] req_data = 0;
  logic msg_valid;
  logic msg_ready = 0;
  logic [1:0] msg_kind;
  logic [1:0] msg_node;
  logic [2:0] msg_addr;
  logic [15:0] msg_data;
  logic own_valid = 0;
  logic own_ready;
  logic [15:0] own_data = 0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dir_home u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_node(msg_node), .msg_addr(msg_addr), .msg_data(msg_data),
    .own_valid(own_valid), .own_ready(own_ready), .own_data(own_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [1:0] n, input logic [2:0] a, input logic [15:0] d);
    int w;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_node = n; req_addr = a; req_data = d;
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic take(input logic [1:0] k, input logic [1:0] n, input logic [2:0] a,
                      input logic [15:0] d, input int hold, input string req);
    int w;
    logic [22:0] first, now;
    w = 0;
    while (!msg_valid && w < 100) begin @(negedge clk); w++; end
    first = {msg_kind, msg_node, msg_addr, msg_data};
    for (int h = 0; h < hold; h++) @(negedge clk);
    now = {msg_kind, msg_node, msg_addr, msg_data};
    if (hold > 0) check(msg_valid && now == first, "R11 hold", {9'd0, now}, {9'd0, first});
    check(msg_valid && now == {k, n, a, d}, req, {8'd0, msg_valid, now}, {9'd1, k, n, a, d});
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic owner(input logic [15:0] d);
    int w;
    w = 0;
    while (!own_ready && w < 100) begin @(negedge clk); w++; end
    check(own_ready, "R10 own_ready", {31'd0, own_ready}, 32'd1);
    own_valid = 1; own_data = d;
    @(negedge clk);
    own_valid = 0;
  endtask

  task automatic quiet(input int cyc, input string req);
    bit seen;
    seen = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (msg_valid || !req_ready) seen = 1;
    end
    check(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready && !msg_valid && !own_ready, "R1 idle outputs",
          {29'd0, req_ready, msg_valid, own_ready}, 32'h4);
    send(2'd0, 2'd0, 3'd7, 16'h0);
    take(2'd0, 2'd0, 3'd7, 16'h0000, 0, "R1 zero data / R2 reply");
  endtask

  task automatic t_read_then_write;
    send(2'd0, 2'd1, 3'd2, 16'h0);
    take(2'd0, 2'd1, 3'd2, 16'h0000, 0, "R2 read miss uncached");
    send(2'd1, 2'd3, 3'd2, 16'h0);
    take(2'd1, 2'd1, 3'd2, 16'h0000, 0, "R2 sole sharer invalidated / R5");
    take(2'd0, 2'd3, 3'd2, 16'h0000, 0, "R5 reply after invalidate");
  endtask

  task automatic t_write_exclusive;
    send(2'd1, 2'd0, 3'd2, 16'h0);
    take(2'd3, 2'd3, 3'd2, 16'h0000, 0, "R7 fetch-invalidate to owner");
    owner(16'hBEEF);
    take(2'd0, 2'd0, 3'd2, 16'hBEEF, 0, "R7 owner data forwarded");
  endtask

  task automatic t_read_exclusive;
    send(2'd0, 2'd2, 3'd2, 16'h0);
    take(2'd2, 2'd0, 3'd2, 16'h0000, 0, "R6 fetch to owner / R7 new owner");
    owner(16'h1234);
    take(2'd0, 2'd2, 3'd2, 16'h1234, 0, "R6 owner data forwarded");
    send(2'd0, 2'd1, 3'd2, 16'h0);
    take(2'd0, 2'd1, 3'd2, 16'h1234, 0, "R4 read shared from memory / R6 memory written");
  endtask

  task automatic t_invalidate_order;
    send(2'd1, 2'd2, 3'd2, 16'h0);
    take(2'd1, 2'd0, 3'd2, 16'h0000, 3, "R5 first invalidate node0");
    take(2'd1, 2'd1, 3'd2, 16'h0000, 2, "R5 second invalidate node1 / R4");
    take(2'd0, 2'd2, 3'd2, 16'h1234, 1, "R5 reply after last invalidate");
  endtask

  task automatic t_writeback;
    send(2'd2, 2'd1, 3'd2, 16'h5555);
    quiet(5, "R9 non-owner write-back silent");
    send(2'd2, 2'd2, 3'd2, 16'hA5A5);
    quiet(5, "R8 owner write-back silent");
    send(2'd1, 2'd1, 3'd2, 16'h0);
    take(2'd0, 2'd1, 3'd2, 16'hA5A5, 0, "R8 uncached with written data / R9 not taken");
    send(2'd0, 2'd0, 3'd2, 16'h0);
    take(2'd2, 2'd1, 3'd2, 16'h0000, 0, "R3 owner after write miss");
    owner(16'h0F0F);
    take(2'd0, 2'd0, 3'd2, 16'h0F0F, 0, "R6 reply");
    send(2'd2, 2'd0, 3'd2, 16'hDEAD);
    quiet(5, "R9 write-back to shared silent");
    send(2'd0, 2'd3, 3'd2, 16'h0);
    take(2'd0, 2'd3, 3'd2, 16'h0F0F, 0, "R9 memory unchanged by shared write-back");
  endtask

  task automatic t_stall;
    int w;
    send(2'd1, 2'd2, 3'd5, 16'h0);
    take(2'd0, 2'd2, 3'd5, 16'h0000, 0, "R3 write miss uncached");
    send(2'd0, 2'd1, 3'd5, 16'h0);
    take(2'd2, 2'd2, 3'd5, 16'h0000, 0, "R3 owner fetched");
    @(negedge clk);
    req_valid = 1; req_kind = 2'd0; req_node = 2'd3; req_addr = 3'd5; req_data = 16'h0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!req_ready, "R10 stalled during owner wait", {31'd0, req_ready}, 32'd0);
    end
    owner(16'h4242);
    take(2'd0, 2'd1, 3'd5, 16'h4242, 0, "R10 first request served first");
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    @(negedge clk);
    req_valid = 0;
    take(2'd0, 2'd3, 3'd5, 16'h4242, 0, "R10 held request served after / R4");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_read_then_write;
    t_write_exclusive;
    t_read_exclusive;
    t_invalidate_order;
    t_writeback;
    t_stall;
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule